// File: doc/BRIEF.md
# Shift-and-Add-3 Binary to BCD Converter

This block turns an unsigned binary operand into packed decimal digits by running the add-3 ("double dabble") method one step at a time. A single `start` pulse loads the operand into the low end of a combined shift chain and clears every decimal column. The controller then alternates between two kinds of cycle. In a correction cycle, every column that holds five or more has three added to it. In a shift cycle, the whole chain moves one bit to the left. It repeats this until every operand bit has been shifted into the decimal columns.

Once the last shift has been made, `ready` rises and the digits sit steady on `bcd_out` until the next accepted `start`. A `start` that arrives while a conversion is running has no effect. The defaults give a 10-bit operand and four digits: thousands, hundreds, tens and units.

Top module: `bcd_dabble_conv`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ready` is low and `bcd_out` is all zeros.
- R2: A `start` seen while the block is idle or finished loads `bin_in` and clears all columns. In the next cycle `ready` is low and `bcd_out` reads zero.
- R3: When `ready` is high, `bcd_out` holds the decimal value of the loaded operand. Thousands are in bits [15:12], hundreds in [11:8], tens in [7:4] and units in [3:0], each as a plain 4-bit BCD code.
- R4: `ready` first reads high 2*IN_W+1 clock edges after the edge that accepted `start`, which is 21 edges for a 10-bit operand.
- R5: Once high, `ready` and `bcd_out` stay unchanged for as long as `start` stays low.
- R6: A `start` seen during a conversion is ignored. The result and its latency are those of the operand loaded first.
- R7: While `ready` is high, no digit of `bcd_out` exceeds 9.
- R8: Each column is corrected on its own and no carry passes to its neighbour. Operands in which several columns need correction in the same step (for example 999 and 1023, which gives 1, 0, 2, 3) convert correctly.
- R9: An operand of zero gives all-zero digits.
- R10: A `start` seen while `ready` is high begins a new conversion, and `ready` is low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a conversion of `bin_in` when the block is not busy |
| bin_in | input | IN_W | Unsigned binary operand |
| ready | output | 1 | High once the digits are complete; held until the next accepted start |
| bcd_out | output | 4*DIGITS | Packed BCD digits, most significant digit in the top nibble |

## Verification
The bench builds the block with its defaults, IN_W = 10 and DIGITS = 4. At that size every operand from 0 to 1023 can be converted and compared against the decimal digits, so each combination of column corrections is reached, including the top value. The bench also measures the latency of each conversion, pulses `start` in the middle of runs with a different operand, and leaves a finished result idle to confirm that it holds.

// File: rtl/bcd_dabble_pkg.sv
// Package: types shared by the converter's controller and datapath.
// Assumes: nothing beyond IEEE 1800-2017.
package bcd_dabble_pkg;
    // Controller phases: waiting, column correction, chain shift, result held
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIX   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } dab_state_e;

    localparam int unsigned NIBBLE_W = 4;
endpackage

// File: rtl/bcd_col_fix.sv
// Module: one decimal column's comparator and add-3 adder.
// Passes the column through unchanged when it is below five and adds three otherwise.
// Assumes: the input is a legal BCD value (0..9), so the sum fits in 4 bits and
// no carry has to leave the column.
module bcd_col_fix
    import bcd_dabble_pkg::*;
(
    input  logic [NIBBLE_W-1:0] col_in,
    output logic [NIBBLE_W-1:0] col_out
);
    logic ge_five;

    // Comparator and adder: detect a value of five or more and add three
    always_comb begin
        ge_five = (col_in >= NIBBLE_W'(5));
        col_out = ge_five ? (col_in + NIBBLE_W'(3)) : col_in;
    end
endmodule

// File: rtl/bcd_shift_chain.sv
// Module: the combined BCD/binary shift chain with parallel load.
// The low IN_W bits hold the operand; above them sit DIGITS decimal columns.
// Assumes: load, fix and shift are mutually exclusive (the controller guarantees it).
module bcd_shift_chain
    import bcd_dabble_pkg::*;
#(
    parameter int unsigned IN_W   = 10,
    parameter int unsigned DIGITS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       fix,
    input  logic                       shift,
    input  logic [IN_W-1:0]            bin_in,
    output logic [DIGITS*NIBBLE_W-1:0] digits
);
    localparam int unsigned BCD_W = DIGITS * NIBBLE_W;

    logic [IN_W-1:0]  bin_r;
    logic [BCD_W-1:0] bcd_r;
    logic [BCD_W-1:0] bcd_fixed;

    // One independent comparator and adder per column
    for (genvar g = 0; g < DIGITS; g++) begin : g_col
        bcd_col_fix u_fix (
            .col_in  (bcd_r[g*NIBBLE_W +: NIBBLE_W]),
            .col_out (bcd_fixed[g*NIBBLE_W +: NIBBLE_W])
        );
    end

    // Chain register: load the operand, correct the columns or shift the chain left by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_r <= '0;
            bcd_r <= '0;
        end else if (load) begin
            bin_r <= bin_in;
            bcd_r <= '0;
        end else if (fix) begin
            bcd_r <= bcd_fixed;
        end else if (shift) begin
            {bcd_r, bin_r} <= {bcd_r[BCD_W-2:0], bin_r, 1'b0};
        end
    end

    assign digits = bcd_r;
endmodule

// File: rtl/bcd_dabble_ctrl.sv
// Module: controller that sequences load, correction and shift steps.
// Accepts start only when idle or finished, then makes IN_W correction/shift
// pairs and holds ready until the next accepted start.
// Assumes: IN_W >= 1.
module bcd_dabble_ctrl
    import bcd_dabble_pkg::*;
#(
    parameter int unsigned IN_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic fix,
    output logic shift,
    output logic ready,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(IN_W + 1);
    localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(IN_W - 1);

    dab_state_e       state_q;
    logic [CNT_W-1:0] shift_cnt_q;

    // Decode the datapath strobes and status from the current phase
    always_comb begin
        busy  = (state_q == ST_FIX) || (state_q == ST_SHIFT);
        load  = start && !busy;
        fix   = (state_q == ST_FIX);
        shift = (state_q == ST_SHIFT);
        ready = (state_q == ST_DONE);
    end

    // Phase register and shift counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            shift_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_q     <= ST_FIX;
                        shift_cnt_q <= '0;
                    end
                end
                ST_FIX: state_q <= ST_SHIFT;
                ST_SHIFT: begin
                    if (shift_cnt_q == LAST_SHIFT) begin
                        state_q <= ST_DONE;
                    end else begin
                        state_q     <= ST_FIX;
                        shift_cnt_q <= shift_cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bcd_dabble_conv.sv
// Module: top of the shift-and-add-3 binary to BCD converter.
// Joins the controller to the shift chain. bcd_out is valid while ready is high.
// Assumes: the operand is unsigned and DIGITS is large enough for 2**IN_W-1.
module bcd_dabble_conv
    import bcd_dabble_pkg::*;
#(
    parameter int unsigned IN_W   = 10,
    parameter int unsigned DIGITS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [IN_W-1:0]            bin_in,
    output logic                       ready,
    output logic [DIGITS*NIBBLE_W-1:0] bcd_out
);
    logic ctl_load;
    logic ctl_fix;
    logic ctl_shift;
    logic ctl_busy;

    bcd_dabble_ctrl #(.IN_W(IN_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (ctl_load),
        .fix   (ctl_fix),
        .shift (ctl_shift),
        .ready (ready),
        .busy  (ctl_busy)
    );

    bcd_shift_chain #(.IN_W(IN_W), .DIGITS(DIGITS)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctl_load),
        .fix    (ctl_fix),
        .shift  (ctl_shift),
        .bin_in (bin_in),
        .digits (bcd_out)
    );
endmodule

// File: rtl/bcd_dabble_chk.sv
// Module: checker with the converter's timing and output properties; bound to the top.
// Assumes: reset is asserted at time zero.
module bcd_dabble_chk
    import bcd_dabble_pkg::*;
#(
    parameter int unsigned IN_W   = 10,
    parameter int unsigned DIGITS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       ready,
    input logic                       busy,
    input logic [DIGITS*NIBBLE_W-1:0] bcd_out
);
    localparam int unsigned LAT   = 2 * IN_W + 1;
    localparam int unsigned LAT_W = $clog2(LAT + 2) + 1;

    logic [LAT_W-1:0] lat_cnt;

    // Count the edges since the last accepted start, stopping once ready is seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (start && !busy) begin
            lat_cnt <= LAT_W'(1);
        end else if (!ready && lat_cnt != '0) begin
            lat_cnt <= lat_cnt + LAT_W'(1);
        end
    end

    a_r1_ready_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !ready);

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (lat_cnt == LAT_W'(LAT)));

    a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> (ready && $stable(bcd_out)));

    a_r6_busy_excludes_ready: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);

    a_r10_restart_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        a_r7_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            ready |-> (bcd_out[g*NIBBLE_W +: NIBBLE_W] <= NIBBLE_W'(9)));
    end
endmodule

bind bcd_dabble_conv bcd_dabble_chk #(.IN_W(IN_W), .DIGITS(DIGITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ready   (ready),
    .busy    (ctl_busy),
    .bcd_out (bcd_out)
);

// File: tb/test_bcd_dabble_conv.sv
`timescale 1ns/1ps
// Bench: scoreboard for the converter. The driver task pushes expected digits into a queue
// and the monitor pops and compares them when ready rises.
module test_bcd_dabble_conv;
    localparam int unsigned IN_W   = 10;
    localparam int unsigned DIGITS = 4;
    localparam int unsigned LAT    = 2 * IN_W + 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [IN_W-1:0]     bin_in = '0;
    logic                ready;
    logic [DIGITS*4-1:0] bcd_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [DIGITS*4-1:0] exp_q[$];
    logic ready_q = 1'b0;

    always #2 clk = ~clk;

    bcd_dabble_conv #(.IN_W(IN_W), .DIGITS(DIGITS)) i_bcd_dabble_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .bin_in(bin_in),
        .ready(ready), .bcd_out(bcd_out)
    );

    function automatic logic [DIGITS*4-1:0] to_bcd(input int v);
        logic [DIGITS*4-1:0] r = '0;
        int x = v;
        for (int d = 0; d < DIGITS; d++) begin
            r[d*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: on each rising ready, pop the oldest expected result and compare (R3, R7)
    always @(negedge clk) begin
        if (rst_n && ready && !ready_q) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected result", int'(bcd_out), 0);
            end else begin
                logic [DIGITS*4-1:0] e;
                e = exp_q.pop_front();
                check(bcd_out == e, "R3 digits", int'(bcd_out), int'(e));
            end
        end
        ready_q <= ready;
    end

    // Driver: start one conversion; optionally pulse start with another operand mid-run (R6)
    task automatic convert(input int v, input bit glitch);
        int n;
        @(negedge clk);
        start  = 1'b1;
        bin_in = IN_W'(v);
        exp_q.push_back(to_bcd(v));
        @(negedge clk);
        start = 1'b0;
        n = 1;
        check(!ready && bcd_out == '0, "R2 load clears", int'({ready, bcd_out}), 0);
        while (!ready && n < 100) begin
            if (glitch && n == 6) begin
                start  = 1'b1;
                bin_in = IN_W'(v ^ 10'h155);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == LAT, glitch ? "R6 latency with ignored start" : "R4 latency", n, LAT);
    endtask

    // Watchdog: end a hung run as a failure
    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [DIGITS*4-1:0] held;
        repeat (3) @(negedge clk);
        check(!ready && bcd_out == '0, "R1 reset state", int'({ready, bcd_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ready && bcd_out == '0, "R1 after release", int'({ready, bcd_out}), 0);

        convert(0, 1'b0);                       // R9 zero operand
        check(bcd_out == '0, "R9 zero", int'(bcd_out), 0);
        convert(1023, 1'b0);                    // R8 top value
        check(bcd_out == 16'h1023, "R8 1023", int'(bcd_out), 16'h1023);
        convert(999, 1'b0);                     // R8 every column corrects
        check(bcd_out == 16'h0999, "R8 999", int'(bcd_out), 16'h0999);

        // R5: result holds while start stays low
        held = bcd_out;
        repeat (6) @(negedge clk);
        check(ready && bcd_out == held, "R5 hold", int'({ready, bcd_out}), int'({1'b1, held}));

        // R10: restart from ready drops ready at once
        start = 1'b1; bin_in = IN_W'(5); exp_q.push_back(to_bcd(5));
        @(negedge clk);
        start = 1'b0;
        check(!ready, "R10 restart drops ready", int'(ready), 0);
        while (!ready) @(negedge clk);

        // R6: starts during a run are ignored
        convert(517, 1'b1);
        convert(88, 1'b1);

        // R3: exhaustive sweep of all operands
        for (int v = 0; v < (1 << IN_W); v++) convert(v, 1'b0);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule